// File: doc/BRIEF.md
# Streaming Binary Corner Transform Encoder

The block takes a binary layout image as a raster-scanned pixel stream, one pixel per accepted handshake. It emits a binary corner image in which a 1 marks a pixel where the horizontal transition pattern of the image changes from one row to the next. In rectilinear artwork those 1s fall on polygon corners. Each output bit depends on the current pixel, the pixel to its left, the pixel directly above and the pixel above-left. The block computes it in a single pass with one row of storage, instead of a horizontal transition pass followed by a vertical pass over a stored frame.

Rows arrive left to right and top to bottom. A start-of-row marker travels with the first pixel of every row. A start-of-frame marker travels with the first pixel of the first row. The image width is a parameter. The output stream has a valid/ready handshake and stays in step with the input: the Nth corner bit out belongs to the Nth pixel in. A one-bit-per-column line buffer holds the previous input row. It is read and rewritten at the current column on every accepted pixel.

Top module: `cxf_top`

## Requirements
- R1: For an accepted pixel at column x, row y, the corner bit is 1 in exactly two cases. Case one: the above-left pixel equals the above pixel and the left pixel differs from the current pixel. Case two: the above-left pixel differs from the above pixel and the left pixel equals the current pixel. In every other case the corner bit is 0. Equivalently, the bit is the XOR of the four pixels.
- R2: A pixel presented with in_row_start = 1 is column 0, and both its left and above-left neighbours are taken as 0.
- R3: A pixel presented with in_frame_start = 1 begins row 0, and every pixel of row 0 takes its above and above-left neighbours as 0. Pixels of a previous frame have no effect on the new frame.
- R4: Over a whole frame, the corner image equals this two-step process. First, each row is encoded left to right, marking 1 where a pixel differs from its left neighbour (0 before column 0). Second, the result is encoded down each column, marking 1 where a value differs from the one above (0 above row 0).
- R5: Lines and single pixels that are one pixel wide, horizontal or vertical, are encoded according to R4.
- R6: A pixel is accepted on a rising edge with in_valid and in_ready high. Its corner bit appears on out_corner with out_valid high after that same edge. out_valid falls after an edge that transfers the output (out_ready high) and accepts no new pixel.
- R7: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, out_corner holds its value. No pixel is accepted and no context state changes, so a stalled stream yields the same corner bits as an unstalled one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel is present |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_pixel | input | 1 | Layout pixel, 1 = filled |
| in_row_start | input | 1 | Pixel is the first of a row |
| in_frame_start | input | 1 | Pixel is the first of a frame (also set in_row_start) |
| out_valid | output | 1 | out_corner holds an untransferred corner bit |
| out_ready | input | 1 | Downstream takes the corner bit this cycle |
| out_corner | output | 1 | Corner bit for the pixel accepted earlier |

## Verification
Every cycle, the assertions check these behaviours: the output register holds its value under backpressure, a valid result follows one cycle after each accepted pixel, context and line-buffer state stay frozen on cycles with no pixel, the first pixel of a frame maps straight to its own value, and a row-start pixel combines only with the stored bit above it. Whole-image equivalence with the two-pass encoding cannot be shown by a local property. Neither can isolation between consecutive frames or the handling of one-pixel-wide features. The bench's scenarios show these: a sweep over all pairs of six-bit row patterns in back-to-back two-row frames, random overlapping rectangles, and line and dot images, with ready toggled at random.

// File: rtl/cxf_pkg.sv
package cxf_pkg;

  // 2x2 neighbourhood around the pixel being encoded
  typedef struct packed {
    logic up_left;
    logic up;
    logic left;
    logic here;
  } nbhd_t;

  // Corner bit: set when exactly one of the row-to-row transition
  // conditions holds, i.e. the parity of the four pixels.
  function automatic logic corner_bit(input nbhd_t n);
    logic top_edge;
    logic cur_edge;
    top_edge = n.up_left ^ n.up;
    cur_edge = n.left ^ n.here;
    return top_edge ^ cur_edge;
  endfunction

  // Next column index with wrap at the row width
  function automatic int unsigned col_step(input int unsigned c, input int unsigned w);
    return (c + 1 >= w) ? 0 : c + 1;
  endfunction

endpackage

// File: rtl/cxf_linebuf.sv
module cxf_linebuf #(
  parameter int WIDTH = 16,
  localparam int COL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [COL_W-1:0] addr,
  input  logic             wr_bit,
  output logic             rd_bit
);

  logic [WIDTH-1:0] bits_q;

  // one storage flop per column, written at the shared read/write address
  for (genvar i = 0; i < WIDTH; i++) begin : g_col
    logic hit;
    assign hit = wr_en && (addr == COL_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)
        bits_q[i] <= 1'b0;
      else if (hit)
        bits_q[i] <= wr_bit;
    end
  end

  assign rd_bit = bits_q[addr];

  AST_BUF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bits_q)); // R7

endmodule

// File: rtl/cxf_context.sv
module cxf_context
  import cxf_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int COL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             row_start,
  input  logic             frame_start,
  input  logic             pix,
  input  logic             above_raw,
  output logic [COL_W-1:0] col_addr,
  output logic             top_row,
  output nbhd_t            nb
);

  logic [COL_W-1:0] col_q;
  logic             left_q;
  logic             upl_q;
  logic             top_q;
  logic             above_eff;

  // column 0 on a row marker; otherwise continue along the row
  assign col_addr  = row_start ? '0 : col_q;
  assign top_row   = frame_start ? 1'b1 : (row_start ? 1'b0 : top_q);
  assign above_eff = top_row ? 1'b0 : above_raw;

  always_comb begin
    nb.here    = pix;
    nb.up      = above_eff;
    nb.left    = row_start ? 1'b0 : left_q;
    nb.up_left = (row_start || top_row) ? 1'b0 : upl_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q  <= '0;
      left_q <= 1'b0;
      upl_q  <= 1'b0;
      top_q  <= 1'b1;
    end else if (adv) begin
      col_q  <= COL_W'(col_step(int'(col_addr), WIDTH));
      left_q <= pix;
      upl_q  <= above_eff;
      top_q  <= top_row;
    end
  end

  AST_CTX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(col_q) && $stable(left_q) && $stable(upl_q) && $stable(top_q)); // R7

  AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col_q) < WIDTH); // R1

  AST_NEW_ROW_COL0: assert property (@(posedge clk) disable iff (!rst_n)
    adv && row_start |=> col_q == COL_W'(col_step(0, WIDTH))); // R2

endmodule

// File: rtl/cxf_outreg.sv
module cxf_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic corner_in,
  input  logic out_ready,
  output logic out_valid,
  output logic out_corner,
  output logic can_take
);

  logic valid_q;
  logic corner_q;

  assign can_take   = !valid_q || out_ready;
  assign out_valid  = valid_q;
  assign out_corner = corner_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      corner_q <= 1'b0;
    end else if (take) begin
      valid_q  <= 1'b1;
      corner_q <= corner_in;
    end else if (out_ready) begin
      valid_q  <= 1'b0;
    end
  end

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_corner)); // R7

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R6

  AST_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    !take && out_ready |=> !out_valid); // R6

endmodule

// File: rtl/cxf_top.sv
module cxf_top
  import cxf_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int COL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_pixel,
  input  logic in_row_start,
  input  logic in_frame_start,
  output logic out_valid,
  input  logic out_ready,
  output logic out_corner
);

  logic             take;
  logic             can_take;
  logic             buf_rd;
  logic             top_row;
  logic [COL_W-1:0] col_addr;
  nbhd_t            nb;
  logic             corner_now;

  assign in_ready   = can_take;
  assign take       = in_valid && can_take;
  assign corner_now = corner_bit(nb);

  cxf_linebuf #(.WIDTH(WIDTH)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (take),
    .addr   (col_addr),
    .wr_bit (in_pixel),
    .rd_bit (buf_rd)
  );

  cxf_context #(.WIDTH(WIDTH)) u_ctx (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv         (take),
    .row_start   (in_row_start || in_frame_start),
    .frame_start (in_frame_start),
    .pix         (in_pixel),
    .above_raw   (buf_rd),
    .col_addr    (col_addr),
    .top_row     (top_row),
    .nb          (nb)
  );

  cxf_outreg u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .corner_in  (corner_now),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_corner (out_corner),
    .can_take   (can_take)
  );

  AST_FRAME_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_frame_start |=> out_corner == $past(in_pixel)); // R3

  AST_ROW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_row_start && !in_frame_start && !top_row
      |=> out_corner == ($past(in_pixel) ^ $past(buf_rd))); // R2

  AST_TOP_ROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    take && top_row |-> !nb.up && !nb.up_left); // R3

endmodule

// File: tb/cxf_top_test.sv
`timescale 1ns/1ps
module cxf_top_test;
  localparam int W = 8;
  localparam int MAXR = 8;
  localparam int QN = 1024;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, in_pixel = 0, in_row_start = 0, in_frame_start = 0;
  logic out_ready = 1;
  logic in_ready, out_valid, out_corner;

  always #4 clk = ~clk;

  cxf_top #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel(in_pixel), .in_row_start(in_row_start), .in_frame_start(in_frame_start),
    .out_valid(out_valid), .out_ready(out_ready), .out_corner(out_corner));

  int n_chk = 0, n_bad = 0;
  bit img [MAXR][W];
  bit expc[MAXR][W];
  bit    q_bit[QN];
  string q_tag[QN];
  int q_wr = 0, q_rd = 0;
  bit running = 0, stall = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // two-pass model: row transitions, then column transitions of that result
  task automatic model(input int rows);
    bit t[MAXR][W];
    for (int y = 0; y < rows; y++)
      for (int x = 0; x < W; x++)
        t[y][x] = img[y][x] ^ ((x > 0) ? img[y][x-1] : 1'b0);
    for (int x = 0; x < W; x++)
      for (int y = 0; y < rows; y++)
        expc[y][x] = t[y][x] ^ ((y > 0) ? t[y-1][x] : 1'b0);
  endtask

  task automatic push(input bit p, input bit rs, input bit fs, input bit e, input string tag);
    bit acc;
    acc = 0;
    while (!acc) begin
      @(negedge clk);
      out_ready = stall ? ($urandom_range(0, 9) < 6) : 1'b1;
      in_valid = 1; in_pixel = p; in_row_start = rs; in_frame_start = fs;
      #2;
      acc = in_ready;
      if (acc) begin
        q_bit[q_wr % QN] = e;
        q_tag[q_wr % QN] = tag;
        q_wr++;
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_row_start = 0; in_frame_start = 0;
  endtask

  task automatic send_frame(input int rows, input string tag);
    string t;
    model(rows);
    for (int y = 0; y < rows; y++)
      for (int x = 0; x < W; x++) begin
        t = (y == 0) ? "R3" : ((x == 0) ? "R2" : tag);
        push(img[y][x], x == 0, (x == 0) && (y == 0), expc[y][x], t);
      end
  endtask

  task automatic clear_img();
    for (int y = 0; y < MAXR; y++)
      for (int x = 0; x < W; x++) img[y][x] = 0;
  endtask

  // monitor: samples shortly before each rising edge
  bit have_prev = 0, exp_v = 0, prev_hold = 0, prev_c = 0;
  always begin
    @(negedge clk); #3;
    if (running) begin
      cycles++;
      check(in_ready == (!out_valid || out_ready), "R7 in_ready", in_ready, !out_valid || out_ready);
      if (have_prev) begin
        check(out_valid == exp_v, "R6 out_valid", out_valid, exp_v);
        if (prev_hold) check(out_corner == prev_c, "R7 held", out_corner, prev_c);
      end
      if (out_valid && out_ready) begin
        if (q_rd < q_wr) begin
          check(out_corner == q_bit[q_rd % QN], q_tag[q_rd % QN], out_corner, q_bit[q_rd % QN]);
          q_rd++;
        end else check(0, "R6 extra output", 1, 0);
      end
      exp_v = (in_valid && in_ready) || (out_valid && !out_ready);
      prev_hold = out_valid && !out_ready;
      prev_c = out_corner;
      have_prev = 1;
      if (cycles > 190000) begin
        check(0, "watchdog", cycles, 190000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R6 reset out_valid", out_valid, 0);
    check(in_ready == 1, "R7 reset in_ready", in_ready, 1);
    @(negedge clk); rst_n = 1;
    running = 1;

    // sweep: every pair of six-bit row patterns, back-to-back two-row frames
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 64; b++) begin
        clear_img();
        for (int x = 0; x < 6; x++) begin
          img[0][x+1] = a[x];
          img[1][x+1] = b[x];
        end
        stall = ((a + b) % 3 == 0);
        send_frame(2, "R1");
      end

    // random Manhattan rectangles (R4)
    for (int f = 0; f < 40; f++) begin
      clear_img();
      for (int r = 0; r < 3; r++) begin
        int x0, x1, y0, y1;
        x0 = $urandom_range(0, W-1); x1 = $urandom_range(x0, W-1);
        y0 = $urandom_range(0, MAXR-1); y1 = $urandom_range(y0, MAXR-1);
        for (int y = y0; y <= y1; y++)
          for (int x = x0; x <= x1; x++) img[y][x] = 1;
      end
      stall = f[0];
      send_frame(MAXR, "R4");
    end

    // one-pixel-wide features (R5)
    for (int f = 0; f < 24; f++) begin
      int k;
      clear_img();
      k = f % W;
      case (f / W)
        0: for (int x = 0; x < W; x++) img[k][x] = 1;
        1: for (int y = 0; y < MAXR; y++) img[y][k] = 1;
        default: begin
          img[k][k] = 1;
          img[k][(k + 3) % W] = 1;
          for (int y = 0; y < MAXR; y++) img[y][(k + 5) % W] = 1;
          for (int x = 0; x < W; x++) img[(k + 2) % MAXR][x] = 1;
        end
      endcase
      stall = (f % 2 == 1);
      send_frame(MAXR, "R5");
    end

    stall = 0;
    @(negedge clk); out_ready = 1;
    repeat (6) @(negedge clk);
    check(q_rd == q_wr, "R6 all outputs delivered", q_rd, q_wr);
    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule